// File: doc/BRIEF.md
# Paged MDIO Register Bridge

This block lets a local host read and write 32-bit registers inside an Ethernet switch that is reachable only over a Clause 22 management bus. The switch packs its wide register space behind a page register and spreads each page across eight PHY addresses. The bridge takes one host request at a time and splits the word address into a page, a PHY-address offset and an even register number. It first writes the page, then moves the two 16-bit halves of the register as separate management frames. It drives the MDC clock and the MDIO pin enable itself.

Besides plain reads and writes, the bridge offers two compound operations. A read-modify-write replaces the masked bits of a register. A poll re-reads a register until its masked value equals an expected value, and gives up after a bounded number of attempts with a timeout flag. Requests use a valid/ready handshake. The response is a single-cycle strobe that carries the read data and the timeout flag.

Top module: `paged_mdio_bridge`

## Requirements
- R1: For word address `wa` (byte address bits 17:2), the halfword frames go to PHY address `5'h10 | wa[6:4]`. The low half uses register `{wa[3:0],1'b0}` and the high half that register plus one. The page number is `wa[15:7]`.
- R2: Every 32-bit access, including each poll attempt and each phase of a read-modify-write, starts with a write frame to PHY address 0x18, register 0, that carries the 9-bit page zero-extended to 16 bits.
- R3: A read (`req_op` = 0) reads the low half first and the high half second. It returns `{high, low}` on `rsp_rdata` with `rsp_timeout` = 0.
- R4: A write (`req_op` = 1) sends `wdata[31:16]` to the odd register first and `wdata[15:0]` to the even register after it. The response returns the written word.
- R5: A read-modify-write (`req_op` = 2) reads the register as in R3. It then does a fresh page write and writes `(old & ~mask) | wdata` as in R4, and returns that value.
- R6: A poll (`req_op` = 3) repeats full reads until `(value & mask) == wdata`. It returns the matching value with `rsp_timeout` = 0.
- R7: A poll whose 20th read (`POLL_LIMIT`) still does not match ends with `rsp_timeout` = 1 and the last value read. It makes no further frames.
- R8: Each frame is 64 bits, most significant first: 32 ones, start `01`, opcode `01` for a write or `10` for a read, 5-bit PHY address, 5-bit register, turnaround `10` and 16 data bits. On a read, `mdio_oe` is low from the turnaround to the end of the frame. Between frames `mdio_oe` is low.
- R9: `mdio_o` changes only while MDC is low, just after a falling edge. Read data is taken at MDC rising edges.
- R10: `req_ready` drops in the cycle after a request is accepted and stays low until the cycle in which `rsp_valid` is high. `rsp_valid` lasts exactly one cycle.
- R11: After reset `req_ready` is 1, and `rsp_valid` and `mdio_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge idle and able to accept |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 poll |
| req_word_addr | input | 16 | Register word address (byte address bits 17:2) |
| req_wdata | input | 32 | Write value, OR value or poll target |
| req_mask | input | 32 | Clear mask for read-modify-write, compare mask for poll |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read, written or last polled value |
| rsp_timeout | output | 1 | Poll exhausted its attempts |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data drive enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions take for granted that the clock divider setting keeps at least two system cycles per MDC half period. They also assume reset is held for several cycles before the first request. They assume the request fields matter only in the accepting cycle, and that `mdio_i` is stable across each MDC rising edge during the data bits of a read. The bench keeps to this: its switch model changes `mdio_i` only at MDC falling edges. It changes request fields only while `req_valid` is low or before acceptance, and it raises one request at a time after seeing `req_ready`.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

    localparam int DATA_W    = 32;
    localparam int HALF_W    = 16;
    localparam int PAGE_W    = 9;
    localparam int OFF_W     = 3;
    localparam int REGN_W    = 5;
    localparam int PHYA_W    = 5;
    localparam int WADDR_W   = PAGE_W + OFF_W + REGN_W - 1;
    localparam int FRAME_LEN = 64;

    localparam logic [PHYA_W-1:0] PAGE_PHY      = 5'h18;
    localparam logic [REGN_W-1:0] PAGE_REGN     = 5'h00;
    localparam logic [PHYA_W-1:0] HALF_PHY_BASE = 5'h10;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_RMW   = 2'd2,
        OP_POLL  = 2'd3
    } bridge_op_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  phy_off;
        logic [REGN_W-1:0] reg_lo;
    } reg_loc_t;

    typedef struct packed {
        logic              is_read;
        logic [PHYA_W-1:0] phy;
        logic [REGN_W-1:0] regn;
        logic [HALF_W-1:0] wdata;
    } mdio_cmd_t;

    function automatic reg_loc_t locate(input logic [WADDR_W-1:0] wa);
        reg_loc_t l;
        l.reg_lo  = {wa[REGN_W-2:0], 1'b0};
        l.phy_off = wa[REGN_W-1+OFF_W-1:REGN_W-1];
        l.page    = wa[WADDR_W-1:WADDR_W-PAGE_W];
        return l;
    endfunction

    function automatic mdio_cmd_t page_cmd(input reg_loc_t l);
        mdio_cmd_t c;
        c.is_read = 1'b0;
        c.phy     = PAGE_PHY;
        c.regn    = PAGE_REGN;
        c.wdata   = HALF_W'(l.page);
        return c;
    endfunction

    function automatic mdio_cmd_t half_cmd(input logic rd, input reg_loc_t l,
                                           input logic hi, input logic [HALF_W-1:0] d);
        mdio_cmd_t c;
        c.is_read = rd;
        c.phy     = HALF_PHY_BASE | PHYA_W'(l.phy_off);
        c.regn    = l.reg_lo | REGN_W'(hi);
        c.wdata   = d;
        return c;
    endfunction

    function automatic logic [FRAME_LEN-1:0] frame_bits(input mdio_cmd_t c);
        return {32'hFFFF_FFFF, 2'b01,
                c.is_read ? 2'b10 : 2'b01,
                c.phy, c.regn,
                c.is_read ? 2'b11 : 2'b10,
                c.is_read ? 16'hFFFF : c.wdata};
    endfunction

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            mdc       <= 1'b0;
            rise_tick <= 1'b0;
            fall_tick <= 1'b0;
        end else begin
            rise_tick <= 1'b0;
            fall_tick <= 1'b0;
            if (cnt == CW'(DIV_HALF - 1)) begin
                cnt       <= '0;
                mdc       <= ~mdc;
                rise_tick <= ~mdc;
                fall_tick <= mdc;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_fall_low_r9: assert property (@(posedge clk) disable iff (rst)
        fall_tick |-> !mdc);
    p_rise_high_r9: assert property (@(posedge clk) disable iff (rst)
        rise_tick |-> mdc);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic [HALF_W-1:0] rdata,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int IW = $clog2(FRAME_LEN) + 1;
    localparam logic [IW-1:0]   TA_AT   = IW'(FRAME_LEN - HALF_W - 2);
    localparam logic [IW-2:0]   DATA_AT = (IW-1)'(FRAME_LEN - HALF_W);
    localparam logic [IW-2:0]   LAST_AT = (IW-1)'(FRAME_LEN - 1);

    logic [FRAME_LEN-1:0] sh;
    logic                 is_rd;
    logic [IW-1:0]        bitidx;
    logic [IW-2:0]        cur;
    logic                 launched;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '1;
            is_rd    <= 1'b0;
            bitidx   <= '0;
            cur      <= '0;
            launched <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            rdata    <= '0;
            mdio_o   <= 1'b1;
            mdio_oe  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    sh       <= frame_bits(cmd);
                    is_rd    <= cmd.is_read;
                    bitidx   <= '0;
                    launched <= 1'b0;
                    busy     <= 1'b1;
                end
            end else begin
                if (fall_tick && bitidx < IW'(FRAME_LEN)) begin
                    mdio_o   <= sh[FRAME_LEN-1];
                    sh       <= {sh[FRAME_LEN-2:0], 1'b1};
                    mdio_oe  <= !(is_rd && bitidx >= TA_AT);
                    cur      <= bitidx[IW-2:0];
                    bitidx   <= bitidx + 1'b1;
                    launched <= 1'b1;
                end
                if (rise_tick && launched) begin
                    if (is_rd && cur >= DATA_AT)
                        rdata <= {rdata[HALF_W-2:0], mdio_i};
                    if (cur == LAST_AT) begin
                        done    <= 1'b1;
                        busy    <= 1'b0;
                        mdio_oe <= 1'b0;
                    end
                end
            end
        end
    end

    // R9: the pin moves only on the strobe that follows an MDC falling edge
    p_launch_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
        !fall_tick |=> $stable(mdio_o));
    // R8: pin released for turnaround and data of a read
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && launched && is_rd && cur >= TA_AT[IW-2:0]) |-> !mdio_oe);
    p_idle_undriven_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

endmodule

// File: rtl/bridge_sequencer.sv
module bridge_sequencer
    import mdio_bridge_pkg::*;
#(
    parameter int POLL_LIMIT = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_op,
    input  logic [WADDR_W-1:0] req_word_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [DATA_W-1:0]  req_mask,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_timeout,
    input  logic               eng_busy,
    input  logic               eng_done,
    input  logic [HALF_W-1:0]  eng_rdata,
    output logic               eng_start,
    output mdio_cmd_t          eng_cmd
);
    localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_PAGE, SQ_RD_LO, SQ_RD_HI, SQ_WR_HI, SQ_WR_LO
    } seq_state_e;

    seq_state_e          state;
    bridge_op_e          op_q;
    reg_loc_t            loc_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   mask_q;
    logic [DATA_W-1:0]   wr_word;
    logic [HALF_W-1:0]   lo_half;
    logic                wr_phase;
    logic                issued;
    logic [PW-1:0]       tries;

    logic [DATA_W-1:0]   rd_word_c;
    logic [DATA_W-1:0]   merged_c;
    logic                match_c;

    always_comb begin
        rd_word_c = {eng_rdata, lo_half};
        merged_c  = (rd_word_c & ~mask_q) | wdata_q;
        match_c   = ((rd_word_c & mask_q) == wdata_q);
        req_ready = (state == SQ_IDLE);
        eng_start = (state != SQ_IDLE) && !issued;
        unique case (state)
            SQ_PAGE:  eng_cmd = page_cmd(loc_q);
            SQ_RD_LO: eng_cmd = half_cmd(1'b1, loc_q, 1'b0, '0);
            SQ_RD_HI: eng_cmd = half_cmd(1'b1, loc_q, 1'b1, '0);
            SQ_WR_HI: eng_cmd = half_cmd(1'b0, loc_q, 1'b1, wr_word[DATA_W-1:HALF_W]);
            SQ_WR_LO: eng_cmd = half_cmd(1'b0, loc_q, 1'b0, wr_word[HALF_W-1:0]);
            default:  eng_cmd = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SQ_IDLE;
            op_q        <= OP_READ;
            loc_q       <= '0;
            wdata_q     <= '0;
            mask_q      <= '0;
            wr_word     <= '0;
            lo_half     <= '0;
            wr_phase    <= 1'b0;
            issued      <= 1'b0;
            tries       <= '0;
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            rsp_timeout <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (state == SQ_IDLE) begin
                if (req_valid) begin
                    op_q        <= bridge_op_e'(req_op);
                    loc_q       <= locate(req_word_addr);
                    wdata_q     <= req_wdata;
                    mask_q      <= req_mask;
                    wr_word     <= req_wdata;
                    wr_phase    <= (bridge_op_e'(req_op) == OP_WRITE);
                    tries       <= '0;
                    issued      <= 1'b0;
                    rsp_timeout <= 1'b0;
                    state       <= SQ_PAGE;
                end
            end else begin
                if (eng_start)
                    issued <= 1'b1;
                if (issued && eng_done) begin
                    issued <= 1'b0;
                    unique case (state)
                        SQ_PAGE:  state <= wr_phase ? SQ_WR_HI : SQ_RD_LO;
                        SQ_RD_LO: begin
                            lo_half <= eng_rdata;
                            state   <= SQ_RD_HI;
                        end
                        SQ_RD_HI: begin
                            unique case (op_q)
                                OP_RMW: begin
                                    wr_word  <= merged_c;
                                    wr_phase <= 1'b1;
                                    state    <= SQ_PAGE;
                                end
                                OP_POLL: begin
                                    if (match_c || tries == PW'(POLL_LIMIT - 1)) begin
                                        rsp_valid   <= 1'b1;
                                        rsp_rdata   <= rd_word_c;
                                        rsp_timeout <= !match_c;
                                        state       <= SQ_IDLE;
                                    end else begin
                                        tries <= tries + 1'b1;
                                        state <= SQ_PAGE;
                                    end
                                end
                                default: begin
                                    rsp_valid <= 1'b1;
                                    rsp_rdata <= rd_word_c;
                                    state     <= SQ_IDLE;
                                end
                            endcase
                        end
                        SQ_WR_HI: state <= SQ_WR_LO;
                        SQ_WR_LO: begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= wr_word;
                            state     <= SQ_IDLE;
                        end
                        default:  state <= SQ_IDLE;
                    endcase
                end
            end
        end
    end

    p_start_idle_r10: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !eng_busy);
    p_ready_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    p_timeout_poll_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_timeout) |-> (op_q == OP_POLL));
    p_poll_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (state != SQ_IDLE) |-> (int'(tries) < POLL_LIMIT));

endmodule

// File: rtl/paged_mdio_bridge.sv
module paged_mdio_bridge
    import mdio_bridge_pkg::*;
#(
    parameter int DIV_HALF   = 2,
    parameter int POLL_LIMIT = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_op,
    input  logic [WADDR_W-1:0] req_word_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [DATA_W-1:0]  req_mask,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_timeout,
    output logic               mdc,
    output logic               mdio_o,
    output logic               mdio_oe,
    input  logic               mdio_i
);
    logic              rise_tick;
    logic              fall_tick;
    logic              eng_start;
    logic              eng_busy;
    logic              eng_done;
    logic [HALF_W-1:0] eng_rdata;
    mdio_cmd_t         eng_cmd;

    mdc_divider #(.DIV_HALF(DIV_HALF)) u_div (
        .clk       (clk),
        .rst       (rst),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    bridge_sequencer #(.POLL_LIMIT(POLL_LIMIT)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_op        (req_op),
        .req_word_addr (req_word_addr),
        .req_wdata     (req_wdata),
        .req_mask      (req_mask),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .rsp_timeout   (rsp_timeout),
        .eng_busy      (eng_busy),
        .eng_done      (eng_done),
        .eng_rdata     (eng_rdata),
        .eng_start     (eng_start),
        .eng_cmd       (eng_cmd)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .start     (eng_start),
        .cmd       (eng_cmd),
        .mdio_i    (mdio_i),
        .busy      (eng_busy),
        .done      (eng_done),
        .rdata     (eng_rdata),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

endmodule

// File: tb/paged_mdio_bridge_bench.sv
`timescale 1ns/1ps
module paged_mdio_bridge_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_word_addr = 16'd0;
    logic [31:0] req_wdata = 32'd0;
    logic [31:0] req_mask = 32'd0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_timeout;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done_run = 0;

    always #2.5 clk = ~clk;

    paged_mdio_bridge u_paged_mdio_bridge (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_word_addr(req_word_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_timeout(rsp_timeout), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- switch model on the management pins ----------------
    typedef struct packed {
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] d;
    } xact_t;

    xact_t got_q[$];
    xact_t exp_q[$];
    logic [15:0] phy_mem [0:1023];

    int          fidx = 0;
    bit          in_frame = 0;
    bit          frame_rd = 0;
    logic [63:0] fbits;
    logic [63:0] foe;
    logic [15:0] rd_word;
    int          hook_left = 0;
    logic [9:0]  hook_idx;
    logic [15:0] hook_val;

    always @(posedge mdc) begin
        if (!in_frame && mdio_oe) begin
            in_frame = 1;
            fidx = 0;
            fbits = '0;
            foe = '0;
        end
        if (in_frame) begin
            fbits[63-fidx] = mdio_o;
            foe[63-fidx] = mdio_oe;
            fidx++;
            if (fidx == 46) begin
                frame_rd = (fbits[29:28] == 2'b10);
                rd_word = phy_mem[{fbits[27:23], fbits[22:18]}];
            end
            if (fidx == 64) begin
                xact_t x;
                in_frame = 0;
                chk(fbits[63:32] == 32'hFFFF_FFFF && fbits[31:30] == 2'b01, "R8",
                    "preamble/start", fbits[63:32], 32'hFFFF_FFFF);
                x.phy = fbits[27:23];
                x.rg  = fbits[22:18];
                if (frame_rd) begin
                    chk(foe == {46'h3FFF_FFFF_FFFF, 18'h0}, "R8", "read drive enable",
                        foe[31:0], 32'h0);
                    x.wr = 0;
                    x.d  = rd_word;
                    if (hook_left > 0) begin
                        hook_left--;
                        if (hook_left == 0) phy_mem[hook_idx] = hook_val;
                    end
                end else begin
                    chk(fbits[29:28] == 2'b01 && fbits[17:16] == 2'b10 && foe == '1, "R8",
                        "write opcode/turnaround", {28'h0, fbits[29:28], fbits[17:16]}, 32'h6);
                    x.wr = 1;
                    x.d  = fbits[15:0];
                    phy_mem[{x.phy, x.rg}] = x.d;
                end
                got_q.push_back(x);
            end
        end
    end

    always @(negedge mdc) begin
        if (in_frame && frame_rd && fidx == 47) mdio_i <= 1'b0;
        else if (in_frame && frame_rd && fidx >= 48 && fidx <= 63) mdio_i <= rd_word[63-fidx];
        else mdio_i <= 1'b1;
    end

    // ---------------- per-clock reference checks ----------------
    bit   busy_m = 0;
    logic prev_mdio_o = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            // R9: pin changes only while MDC is low
            chk(!(mdio_o !== prev_mdio_o && mdc), "R9", "mdio_o moved with mdc high",
                {31'h0, mdio_o}, {31'h0, prev_mdio_o});
            // R10: busy between acceptance and response
            if (busy_m && !rsp_valid)
                chk(!req_ready, "R10", "ready while busy", {31'h0, req_ready}, 32'h0);
            if (rsp_valid) begin
                chk(busy_m, "R10", "response without request", 32'h1, {31'h0, busy_m});
                busy_m = 0;
            end
            if (req_valid && req_ready) busy_m = 1;
        end
        prev_mdio_o = mdio_o;
    end

    // ---------------- expectation helpers ----------------
    function automatic logic [9:0] midx(input logic [15:0] wa, input bit hi);
        return {5'h10 | {2'b0, wa[6:4]}, wa[3:0], hi};
    endfunction

    task automatic e_push(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] d);
        xact_t x;
        x.wr = wr; x.phy = phy; x.rg = rg; x.d = d;
        exp_q.push_back(x);
    endtask

    task automatic e_page(input logic [15:0] wa);
        e_push(1, 5'h18, 5'h00, {7'h0, wa[15:7]});
    endtask

    task automatic e_read(input logic [15:0] wa, input logic [31:0] val);
        e_page(wa);
        e_push(0, 5'h10 | {2'b0, wa[6:4]}, {wa[3:0], 1'b0}, val[15:0]);
        e_push(0, 5'h10 | {2'b0, wa[6:4]}, {wa[3:0], 1'b1}, val[31:16]);
    endtask

    task automatic e_write(input logic [15:0] wa, input logic [31:0] val);
        e_page(wa);
        e_push(1, 5'h10 | {2'b0, wa[6:4]}, {wa[3:0], 1'b1}, val[31:16]);
        e_push(1, 5'h10 | {2'b0, wa[6:4]}, {wa[3:0], 1'b0}, val[15:0]);
    endtask

    function automatic logic [31:0] mem_word(input logic [15:0] wa);
        return {phy_mem[midx(wa, 1)], phy_mem[midx(wa, 0)]};
    endfunction

    task automatic check_log(input string req);
        int n;
        chk(got_q.size() == exp_q.size(), req, "frame count", got_q.size(), exp_q.size());
        n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
        for (int i = 0; i < n; i++)
            chk(got_q[i] == exp_q[i], req, $sformatf("frame %0d", i),
                32'(got_q[i]), 32'(exp_q[i]));
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic run_req(input logic [1:0] op, input logic [15:0] wa,
                           input logic [31:0] wd, input logic [31:0] mk,
                           input logic [31:0] exp_data, input bit exp_to,
                           input string req);
        int waitc;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1; req_op = op; req_word_addr = wa; req_wdata = wd; req_mask = mk;
        @(posedge clk);
        #1;
        req_valid = 0;
        waitc = 0;
        @(negedge clk);
        while (!rsp_valid && waitc < 40000) begin
            @(negedge clk);
            waitc++;
        end
        chk(rsp_valid, req, "response arrived", {31'h0, rsp_valid}, 32'h1);
        chk(rsp_rdata == exp_data, req, "response data", rsp_rdata, exp_data);
        chk(rsp_timeout == exp_to, req, "timeout flag", {31'h0, rsp_timeout}, {31'h0, exp_to});
        repeat (4) @(negedge clk);
        check_log(req);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    localparam logic [15:0] WA1 = 16'h52B6; // page 0x0A5, offset 3, regs 0x0C/0x0D
    localparam logic [15:0] WA2 = 16'hFFFF; // page 0x1FF, offset 7, regs 0x1E/0x1F
    localparam logic [15:0] WA3 = 16'h0081; // page 0x001, offset 0, regs 0x02/0x03

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 1024; i++) phy_mem[i] = 16'h1000 + 16'(i * 7);
        repeat (5) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready after reset", {31'h0, req_ready}, 32'h1);
        chk(rsp_valid == 1'b0, "R11", "rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
        chk(mdio_oe == 1'b0, "R11", "mdio_oe after reset", {31'h0, mdio_oe}, 32'h0);

        // R1 R2 R3: plain read, mapping and order
        v = mem_word(WA1);
        e_read(WA1, v);
        run_req(2'd0, WA1, 32'h0, 32'h0, v, 0, "R3");

        // R4: write order high then low
        e_write(WA1, 32'hDEAD_BEEF);
        run_req(2'd1, WA1, 32'hDEAD_BEEF, 32'h0, 32'hDEAD_BEEF, 0, "R4");

        e_read(WA1, 32'hDEAD_BEEF);
        run_req(2'd0, WA1, 32'h0, 32'h0, 32'hDEAD_BEEF, 0, "R3");

        // R1: all address fields at maximum
        v = mem_word(WA2);
        e_read(WA2, v);
        run_req(2'd0, WA2, 32'h0, 32'h0, v, 0, "R1");

        // R5: read-modify-write
        e_read(WA1, 32'hDEAD_BEEF);
        e_write(WA1, 32'hDEAD_34EF);
        run_req(2'd2, WA1, 32'h0000_3400, 32'h0000_FF00, 32'hDEAD_34EF, 0, "R5");

        // R6: poll matching on first attempt
        e_read(WA1, 32'hDEAD_34EF);
        run_req(2'd3, WA1, 32'hDEAD_0000, 32'hFFFF_0000, 32'hDEAD_34EF, 0, "R6");

        // R6 R2: poll that matches on the fourth attempt
        phy_mem[midx(WA3, 0)] = 16'h0000;
        phy_mem[midx(WA3, 1)] = 16'h0000;
        hook_idx = midx(WA3, 0);
        hook_val = 16'h005A;
        hook_left = 6;
        for (int a = 0; a < 3; a++) e_read(WA3, 32'h0);
        e_read(WA3, 32'h0000_005A);
        run_req(2'd3, WA3, 32'h0000_005A, 32'h0000_00FF, 32'h0000_005A, 0, "R6");

        // R7: poll that never matches
        for (int a = 0; a < 20; a++) e_read(WA1, 32'hDEAD_34EF);
        run_req(2'd3, WA1, 32'h0000_0000, 32'hFFFF_FFFF, 32'hDEAD_34EF, 1, "R7");

        // R10: bridge accepts again after a timeout
        e_read(WA3, 32'h0000_005A);
        run_req(2'd0, WA3, 32'h0, 32'h0, 32'h0000_005A, 0, "R10");

        done_run = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule